// File: doc/BRIEF.md
# Low-Side Switch Fault Filter and Latch

This block watches a set of low-side power switch channels through digital comparator flags and decides, once per tick of its clock, whether each channel may keep its gate driven. A channel is commanded on by an active-low control input. While a channel is on, the block watches three flags: an overcurrent flag, an overtemperature flag and an undercurrent flag that stands for open load. While the channel is off, it watches a flag that reports the drain below the short-to-ground threshold. Every flag passes through a digital filter, so a short spike is never taken as a fault.

A short circuit or overtemperature drops the gate enable in the same cycle and holds it off. The hold is released only when the control input is released and then asserted again. Each channel keeps one 2-bit fault code. A more severe fault replaces a milder stored fault, and a milder fault never replaces a more severe one. A clear pulse from the diagnostic interface empties all codes. Open-load reporting has two modes. In sporadic mode a filtered open load is stored at once. In static mode it is held back until the channel is next switched off.

Top module: `lsd_fault_guard`

## Requirements
- R1: After reset every fault code reads 00. A channel's gate enable is 0 whenever its control input is 1. With no fault, the gate enable is 1 whenever the control input is 0.
- R2: An overcurrent flag that is high for SC_TICKS consecutive cycles while the channel is on drops the gate enable in the SC_TICKS-th cycle. A shorter run does not drop it.
- R3: An overtemperature flag drops the gate enable in the same cycle if the channel is on. It has no effect on gate or code while the channel is off.
- R4: After a short-circuit or overtemperature shutdown, the gate enable stays 0 while the control input stays 0, even once the flags clear. It returns only after the control input has been 1 for at least one cycle and is 0 again.
- R5: A short-circuit or overtemperature shutdown stores code 11 in the cycle after the fault.
- R6: A short-to-ground flag that is high for FLT_TICKS consecutive cycles while the channel is off stores code 10. The count restarts when the flag is low and in any cycle where the control input changes. The flag is ignored while the channel is on.
- R7: With ol_sporadic = 1, an undercurrent flag that is high for FLT_TICKS consecutive cycles while the channel is on stores code 01 in the next cycle. The count uses the same restart rules as R6.
- R8: With ol_sporadic = 0, a filtered open load is stored as code 01 only in the cycle after the control input next rises. A channel that is switched off with no filtered open load stores nothing.
- R9: The codes are ordered 11 > 10 > 01 > 00. A new fault replaces the stored code only if the new fault's code is higher.
- R10: A diag_clr pulse makes every stored code 00 in the next cycle. If a fault commits in the same cycle as the clear, the fault's code is stored instead.
- R11: Channels are independent. A fault on one channel changes neither the gate enable nor the code of another.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock; all filter times count its cycles |
| rst_n | input | 1 | Active-low reset |
| ctl_n | input | N_CH | Active-low on command, one bit per channel |
| oc_det | input | N_CH | Overcurrent comparator flag |
| ot_det | input | N_CH | Overtemperature flag |
| scg_det | input | N_CH | Drain below short-to-ground threshold |
| uc_det | input | N_CH | Load current below open-load reference |
| ol_sporadic | input | 1 | 1 = open load stored at once, 0 = stored at switch-off |
| diag_clr | input | 1 | Clear pulse for all stored fault codes |
| gate_en | output | N_CH | Gate drive enable per channel |
| fault_code | output | 2*N_CH | Stored code; channel c uses bits [2c+1:2c] |

## Verification
The bench builds the block with N_CH = 2, SC_TICKS = 4 and FLT_TICKS = 5. At these values the runs one cycle short of each filter time, and runs that reach it exactly, take only a few cycles. This lets the bench probe the restart of the shared filter across a control edge and across a flag drop. The second channel stays on and healthy while the first one trips, which shows that the channels do not interact. A long stretch of random sparse flags then mixes trips, clears and mode changes, and a per-cycle behavioural model is compared against the outputs on every cycle.

// File: rtl/lsd_fault_pkg.sv
package lsd_fault_pkg;

   // Encoding is ordered by severity so that a numeric max is a priority merge.
   typedef enum logic [1:0] {
      FC_NONE  = 2'b00,
      FC_OPEN  = 2'b01,
      FC_SHGND = 2'b10,
      FC_TRIP  = 2'b11
   } fcode_t;

   localparam int unsigned FCODE_W = 2;

   function automatic fcode_t fc_max(input fcode_t a, input fcode_t b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/lsd_run_timer.sv
// Counts consecutive cycles with level high and restart low; hit marks the
// TICKS-th such cycle and every one after it while the run lasts.
module lsd_run_timer #(
   parameter int unsigned TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   input  logic level,
   output logic hit
);
   localparam int unsigned CW = (TICKS > 1) ? $clog2(TICKS) : 1;
   localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

   if (TICKS < 1) begin : g_bad_ticks
      $error("lsd_run_timer: TICKS must be at least 1");
   end

   if (TICKS == 1) begin : g_direct
      assign hit = level & ~restart;
   end else begin : g_count
      logic [CW-1:0] cnt;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            cnt <= '0;
         end else if (restart || !level) begin
            cnt <= '0;
         end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
         end
      end

      assign hit = level & ~restart & (cnt == LAST);
   end

endmodule

// File: rtl/lsd_fault_store.sv
// Holds one fault code; keeps the more severe of stored and candidate code.
module lsd_fault_store
   import lsd_fault_pkg::*;
(
   input  logic   clk,
   input  logic   rst_n,
   input  logic   clr,
   input  fcode_t cand,
   output fcode_t code
);
   fcode_t base;
   fcode_t code_nx;

   always_comb begin
      base    = clr ? FC_NONE : code;
      code_nx = fc_max(base, cand);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         code <= FC_NONE;
      end else begin
         code <= code_nx;
      end
   end

   AST_NO_DOWNGRADE: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr) |=> (code >= $past(code)));                              // R9

   AST_COMMIT_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (cand != FC_NONE) |=> (code >= $past(cand)));                   // R10

   AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && cand == FC_NONE) |=> (code == FC_NONE));                // R10

endmodule

// File: rtl/lsd_fault_channel.sv
// One switch channel: short/overtemp trip latch, shared short-to-ground /
// open-load filter, static open-load hold, and the fault store.
module lsd_fault_channel
   import lsd_fault_pkg::*;
#(
   parameter int unsigned SC_TICKS  = 8,
   parameter int unsigned FLT_TICKS = 16
) (
   input  logic   clk,
   input  logic   rst_n,
   input  logic   ctl_n,
   input  logic   oc,
   input  logic   ot,
   input  logic   scg,
   input  logic   uc,
   input  logic   ol_sporadic,
   input  logic   clr,
   output logic   gate_en,
   output fcode_t code
);
   logic   on;
   logic   ctl_q;
   logic   toggled;
   logic   rise;
   logic   sc_hit;
   logic   trip;
   logic   trip_set;
   logic   flt_level;
   logic   flt_hit;
   logic   scg_hit;
   logic   ol_hit;
   logic   ol_pend;
   logic   ol_commit;
   fcode_t cand;

   assign on      = ~ctl_n;
   assign toggled = ctl_n ^ ctl_q;
   assign rise    = ctl_n & ~ctl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctl_q <= 1'b1;
      end else begin
         ctl_q <= ctl_n;
      end
   end

   // Short-circuit filter: only runs while the stage is commanded on.
   lsd_run_timer #(.TICKS(SC_TICKS)) u_sc_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (ctl_n),
      .level   (oc),
      .hit     (sc_hit)
   );

   assign trip_set = on & (ot | sc_hit);
   assign gate_en  = on & ~trip & ~trip_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         trip <= 1'b0;
      end else if (ctl_n) begin
         trip <= 1'b0;
      end else if (trip_set) begin
         trip <= 1'b1;
      end
   end

   // Shared spike filter: drain flag while off, undercurrent flag while on.
   assign flt_level = ctl_n ? scg : uc;

   lsd_run_timer #(.TICKS(FLT_TICKS)) u_flt_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (toggled),
      .level   (flt_level),
      .hit     (flt_hit)
   );

   assign scg_hit = flt_hit & ctl_n;
   assign ol_hit  = flt_hit & on;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ol_pend <= 1'b0;
      end else if (rise) begin
         ol_pend <= 1'b0;
      end else if (ol_hit && !ol_sporadic) begin
         ol_pend <= 1'b1;
      end
   end

   assign ol_commit = (ol_hit & ol_sporadic) | (rise & ol_pend);

   always_comb begin
      cand = FC_NONE;
      if (ol_commit) cand = fc_max(cand, FC_OPEN);
      if (scg_hit)   cand = fc_max(cand, FC_SHGND);
      if (trip_set)  cand = fc_max(cand, FC_TRIP);
   end

   lsd_fault_store u_store (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .cand  (cand),
      .code  (code)
   );

   AST_GATE_IDLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_n |-> !gate_en);                                            // R1

   AST_TRIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && !ctl_n && !$past(ctl_n) && !$past(gate_en))
         |-> !gate_en);                                               // R4

   AST_STATIC_OL_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
      (!ol_sporadic && !rise && code != FC_OPEN) |=> (code != FC_OPEN)); // R8

   AST_SHGND_ONLY_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctl_n && !ctl_q && code != FC_SHGND && code != FC_TRIP && !ot && !oc)
         |=> (code != FC_SHGND));                                     // R6

endmodule

// File: rtl/lsd_fault_guard.sv
// Array of independent low-side switch fault channels.
module lsd_fault_guard
   import lsd_fault_pkg::*;
#(
   parameter int unsigned N_CH      = 4,
   parameter int unsigned SC_TICKS  = 8,
   parameter int unsigned FLT_TICKS = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [N_CH-1:0]           ctl_n,
   input  logic [N_CH-1:0]           oc_det,
   input  logic [N_CH-1:0]           ot_det,
   input  logic [N_CH-1:0]           scg_det,
   input  logic [N_CH-1:0]           uc_det,
   input  logic                      ol_sporadic,
   input  logic                      diag_clr,
   output logic [N_CH-1:0]           gate_en,
   output logic [FCODE_W*N_CH-1:0]   fault_code
);
   localparam int unsigned CODE_BITS = FCODE_W * N_CH;

   if (N_CH < 1) begin : g_bad_nch
      $error("lsd_fault_guard: N_CH must be at least 1");
   end
   if (SC_TICKS < 1 || FLT_TICKS < 1) begin : g_bad_ticks
      $error("lsd_fault_guard: filter times must be at least 1 tick");
   end
   if (CODE_BITS != 2 * N_CH) begin : g_bad_code
      $error("lsd_fault_guard: fault code width mismatch");
   end

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      fcode_t ch_code;

      lsd_fault_channel #(
         .SC_TICKS  (SC_TICKS),
         .FLT_TICKS (FLT_TICKS)
      ) u_ch (
         .clk         (clk),
         .rst_n       (rst_n),
         .ctl_n       (ctl_n[c]),
         .oc          (oc_det[c]),
         .ot          (ot_det[c]),
         .scg         (scg_det[c]),
         .uc          (uc_det[c]),
         .ol_sporadic (ol_sporadic),
         .clr         (diag_clr),
         .gate_en     (gate_en[c]),
         .code        (ch_code)
      );

      assign fault_code[FCODE_W*c +: FCODE_W] = ch_code;

      AST_OT_DROPS_GATE: assert property (@(posedge clk) disable iff (!rst_n)
         ot_det[c] |-> !gate_en[c]);                                  // R3
   end

endmodule

// File: tb/lsd_fault_guard_bench.sv
module lsd_fault_guard_bench;
   localparam int N  = 2;
   localparam int SC = 4;
   localparam int F  = 5;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [N-1:0] ctl_n = '1;
   logic [N-1:0] oc = '0;
   logic [N-1:0] ot = '0;
   logic [N-1:0] scg = '0;
   logic [N-1:0] uc = '0;
   logic         spor = 1'b0;
   logic         clr = 1'b0;
   logic [N-1:0]   gate_en;
   logic [2*N-1:0] fault_code;

   always #5 clk = ~clk;

   lsd_fault_guard #(.N_CH(N), .SC_TICKS(SC), .FLT_TICKS(F)) u_lsd_fault_guard (
      .clk(clk), .rst_n(rst_n), .ctl_n(ctl_n), .oc_det(oc), .ot_det(ot),
      .scg_det(scg), .uc_det(uc), .ol_sporadic(spor), .diag_clr(clr),
      .gate_en(gate_en), .fault_code(fault_code)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;
   string cur_req = "R1";

   // behavioural reference state
   int m_trip[N], m_sc[N], m_fr[N], m_pend[N], m_code[N], m_prev[N];
   int n_trip[N], n_sc[N], n_fr[N], n_pend[N], n_code[N], n_prev[N];

   function automatic int imax(int a, int b);
      return (a > b) ? a : b;
   endfunction

   task automatic chk(string req, string what, int act, int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < N; c++) begin
         m_trip[c] = 0; m_sc[c] = 0; m_fr[c] = 0;
         m_pend[c] = 0; m_code[c] = 0; m_prev[c] = 1;
      end
   endtask

   // One tick: compare outputs against the model, then advance the model.
   task automatic step(int n);
      for (int k = 0; k < n; k++) begin
         #1;
         for (int c = 0; c < N; c++) begin
            int on, edg, rise, run_sc, sc_hit, trip_set, q, run_f, fhit, cand, g;
            on   = (ctl_n[c] == 1'b0);
            edg  = (int'(ctl_n[c]) != m_prev[c]);
            rise = ctl_n[c] && (m_prev[c] == 0);
            run_sc   = (on && oc[c]) ? m_sc[c] + 1 : 0;
            sc_hit   = (run_sc >= SC);
            trip_set = on && (ot[c] || sc_hit);
            g = on && !m_trip[c] && !trip_set;
            q = !edg && (on ? uc[c] : scg[c]);
            run_f = q ? m_fr[c] + 1 : 0;
            fhit  = (run_f >= F);
            cand = 0;
            if (trip_set) cand = 3;
            if (fhit && !on) cand = imax(cand, 2);
            if (fhit && on && spor) cand = imax(cand, 1);
            if (rise && m_pend[c]) cand = imax(cand, 1);
            chk(cur_req, $sformatf("gate ch%0d", c), int'(gate_en[c]), g);
            chk(cur_req, $sformatf("code ch%0d", c), int'(fault_code[2*c +: 2]), m_code[c]);
            n_code[c] = imax(clr ? 0 : m_code[c], cand);
            n_trip[c] = on ? (m_trip[c] || trip_set) : 0;
            n_pend[c] = rise ? 0 : ((fhit && on && !spor) ? 1 : m_pend[c]);
            n_sc[c]   = (run_sc > 1000) ? 1000 : run_sc;
            n_fr[c]   = (run_f > 1000) ? 1000 : run_f;
            n_prev[c] = int'(ctl_n[c]);
         end
         @(posedge clk);
         for (int c = 0; c < N; c++) begin
            m_code[c] = n_code[c]; m_trip[c] = n_trip[c]; m_pend[c] = n_pend[c];
            m_sc[c] = n_sc[c]; m_fr[c] = n_fr[c]; m_prev[c] = n_prev[c];
         end
         @(negedge clk);
      end
   endtask

   // Explicit expectation, sampled with the current inputs applied.
   task automatic peek(string req, int c, int g_exp, int code_exp);
      #1;
      chk(req, $sformatf("gate ch%0d", c), int'(gate_en[c]), g_exp);
      chk(req, $sformatf("code ch%0d", c), int'(fault_code[2*c +: 2]), code_exp);
   endtask

   task automatic pulse_clr();
      clr = 1'b1; step(1); clr = 1'b0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      peek("R1", 0, 0, 0);
      peek("R1", 1, 0, 0);
      cur_req = "R1";
      ctl_n = '0;
      step(2);
      peek("R1", 0, 1, 0);

      // R2: short overcurrent runs, then a full one
      cur_req = "R2";
      oc[0] = 1'b1; step(SC - 1);
      oc[0] = 1'b0; peek("R2", 0, 1, 0);
      step(1);
      oc[0] = 1'b1; step(SC - 1);
      peek("R2", 0, 0, 0);
      step(1);
      oc[0] = 1'b0;
      peek("R4", 0, 0, 3);
      peek("R5", 0, 0, 3);
      peek("R11", 1, 1, 0);
      cur_req = "R4";
      step(3);
      ctl_n[0] = 1'b1; step(1);
      ctl_n[0] = 1'b0; peek("R4", 0, 1, 3);
      step(1);
      cur_req = "R10";
      pulse_clr();
      peek("R10", 0, 1, 0);

      // R3: overtemperature off (ignored) and on (immediate)
      cur_req = "R3";
      ctl_n[0] = 1'b1; ot[0] = 1'b1; step(3);
      ot[0] = 1'b0; peek("R3", 0, 0, 0);
      ctl_n[0] = 1'b0; step(1);
      ot[0] = 1'b1; peek("R3", 0, 0, 0);
      step(1);
      ot[0] = 1'b0; peek("R5", 0, 0, 3);
      step(1);
      ctl_n[0] = 1'b1; step(1);
      pulse_clr();

      // R6: short to ground while off, with restarts
      cur_req = "R6";
      scg[0] = 1'b1; step(F - 1);
      scg[0] = 1'b0; peek("R6", 0, 0, 0);
      step(1);
      scg[0] = 1'b1; step(F);
      scg[0] = 1'b0; peek("R6", 0, 0, 2);
      pulse_clr();
      ctl_n[0] = 1'b0; step(2);
      scg[0] = 1'b1; step(F + 1);
      peek("R6", 0, 1, 0);
      ctl_n[0] = 1'b1; step(F);
      peek("R6", 0, 0, 0);
      step(1);
      peek("R6", 0, 0, 2);
      scg[0] = 1'b0;

      // R9 / R7: open load cannot replace short to ground; sporadic commits
      cur_req = "R9";
      spor = 1'b1; ctl_n[0] = 1'b0; uc[0] = 1'b1; step(F + 3);
      peek("R9", 0, 1, 2);
      cur_req = "R10";
      pulse_clr();
      peek("R10", 0, 1, 1);
      uc[0] = 1'b0; step(1);
      pulse_clr();
      peek("R10", 0, 1, 0);
      cur_req = "R7";
      uc[0] = 1'b1; step(F - 1);
      peek("R7", 0, 1, 0);
      step(1);
      uc[0] = 1'b0; peek("R7", 0, 1, 1);
      cur_req = "R9";
      ot[0] = 1'b1; step(1);
      ot[0] = 1'b0; peek("R9", 0, 0, 3);
      ctl_n[0] = 1'b1; step(1);
      ctl_n[0] = 1'b0; step(1);
      pulse_clr();

      // R8: static open load waits for switch-off
      cur_req = "R8";
      spor = 1'b0;
      uc[0] = 1'b1; step(F + 3);
      uc[0] = 1'b0; peek("R8", 0, 1, 0);
      step(2);
      ctl_n[0] = 1'b1; step(1);
      peek("R8", 0, 0, 1);
      pulse_clr();
      ctl_n[0] = 1'b0; step(3);
      ctl_n[0] = 1'b1; step(1);
      peek("R8", 0, 0, 0);

      // Mixed random traffic against the model
      cur_req = "R11";
      for (int i = 0; i < 3000; i++) begin
         for (int c = 0; c < N; c++) begin
            if ($urandom_range(0, 19) == 0) ctl_n[c] = ~ctl_n[c];
            if ($urandom_range(0, 9) == 0)  oc[c]  = ~oc[c];
            if ($urandom_range(0, 60) == 0) ot[c]  = 1'b1; else ot[c] = 1'b0;
            if ($urandom_range(0, 7) == 0)  scg[c] = ~scg[c];
            if ($urandom_range(0, 7) == 0)  uc[c]  = ~uc[c];
         end
         if ($urandom_range(0, 99) == 0) spor = ~spor;
         clr = ($urandom_range(0, 40) == 0);
         step(1);
      end
      clr = 1'b0;

      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule